// File: doc/BRIEF.md
# SMBus Slave Read-Transfer Engine

This block is the slave side of a two-wire SMBus/I2C port that serves reads issued by a bus master, with firmware taking part at each step. It watches the open-drain clock and data lines through synchronisers and detects START and STOP conditions. It shifts in the address byte and the direction bit. When the address matches and asks for a read, it raises an interrupt and an ACK-request flag, and it holds SCL low until firmware decides whether to acknowledge.

Once firmware acknowledges and loads a byte, the engine shifts the byte out MSB first. It then releases SDA so the master can drive its acknowledge bit, and it interrupts again only after that ninth clock. Firmware keeps the transfer going by loading a new byte, or lets the engine fall back to receiver mode by clearing the interrupt without loading. A byte written after the master has answered NACK is rejected and sets the error flag. If firmware refuses an address, the engine stays silent until the next START. A 4-bit status vector reports the current condition.

Top module: `smbs_slave_read`

## Requirements
- R1: After reset, or after a reset in the middle of a transfer, scl_oe_o, sda_oe_o, si_o, ackrq_o and err_o are 0 and status_o is 4'b0000.
- R2: With inhibit_i=0, a START followed by an address byte equal to {SLV_ADDR, 1} (sent MSB first, bit 0 = 1 for read) sets si_o and ackrq_o after the eighth SCL falling edge, and SCL is held low while si_o is set. A write bit, a different address or inhibit_i=1 raises no interrupt and leaves SDA undriven during the ninth clock.
- R3: If firmware pulses ack_wr_i with ack_val_i=1 and then pulses si_clr_i, SDA is driven low for the ninth clock, and ackrq_o clears together with si_o.
- R4: If the address is answered with ack_val_i=0, SDA stays released in the ninth clock and in every clock after it, and no interrupt is raised until a new START. A repeated START with a matching read address raises si_o again.
- R5: A byte written through dat_wr_i/dat_i before the address interrupt is cleared is shifted out MSB first. SDA changes only while SCL is low, and status_o[2] (transmit mode) reads 1.
- R6: After the eighth data bit SDA is released for the master's acknowledge. si_o stays 0 until the SCL falling edge that ends that ninth clock, and is set after it.
- R7: After a master ACK, a byte written before si_o is cleared is sent as the next data byte.
- R8: Clearing si_o after a master ACK without writing a byte clears status_o[2]. SDA then stays released and no interrupt is raised for the rest of the transfer.
- R9: A dat_wr_i pulse while si_o is set after a master NACK sets err_o. err_o stays set until the next START clears it.
- R10: status_o is {master=0, transmit mode, start seen, stop seen}, bit 3 down to bit 0. A START sets bit 1 and clears bit 0, si_clr_i clears bit 1, and a STOP sets bit 0 and clears bit 2.
- R11: An acknowledged address with no byte loaded still drives the ACK. Transmit mode is not entered, and the following eight clocks read all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_oe_o | output | 1 | Pulls SCL low when 1 (clock stretch) |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| inhibit_i | input | 1 | 1 blocks slave events at START |
| ack_wr_i | input | 1 | Firmware strobe to record its address answer |
| ack_val_i | input | 1 | 1 = acknowledge address, 0 = refuse |
| dat_wr_i | input | 1 | Firmware strobe to write the data register |
| dat_i | input | DW | Byte to transmit |
| si_clr_i | input | 1 | Firmware strobe to clear the interrupt flag |
| si_o | output | 1 | Interrupt flag |
| ackrq_o | output | 1 | Address awaits a firmware ACK/NACK |
| err_o | output | 1 | Data written after a master NACK |
| status_o | output | 4 | {master, transmit mode, start seen, stop seen} |

## Verification
A vector table sends address bytes that differ in only one respect each: exact match with read, the same address with write, an address one LSB off, an address with the upper bits changed, and a match while inhibited. This separates the compare from the direction check and from the inhibit gate. Directed transfers then vary the firmware answer and the master answer. They cover ACK with data, ACK with no data, NACK, a master ACK followed by a clear without data, and a master NACK followed by a late write. This separates the transmit path, the fallback to receiver mode, the blocking after a refused address and the error path. Two distinct data patterns, 8'hC3 and 8'h5E, confirm bit order and that the second byte reloads the shifter.

// File: rtl/smbs_pkg.sv
package smbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in address byte
    ST_AHOLD,  // address interrupt pending, SCL stretched
    ST_AACK,   // ninth clock of the address (ACK driven)
    ST_TX,     // shifting out a data byte
    ST_MACK,   // master acknowledge clock
    ST_THOLD,  // byte-done interrupt pending, SCL stretched
    ST_PASS,   // receiver mode, lines released until START/STOP
    ST_BLOCK   // address refused, silent until next START
  } smbs_state_e;
endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_now,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw_v;
  logic [1:0] now_v;
  logic [1:0] prv_v;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-1:0], raw_v[g]};
    end
    assign now_v[g] = sr[STAGES-1];
    assign prv_v[g] = sr[STAGES];
  end

  assign scl_rise  = now_v[0] & ~prv_v[0];
  assign scl_fall  = ~now_v[0] & prv_v[0];
  assign sda_now   = now_v[1];
  assign start_det = ~now_v[1] & prv_v[1] & now_v[0] & prv_v[0];
  assign stop_det  = now_v[1] & ~prv_v[1] & now_v[0] & prv_v[0];
endmodule

// File: rtl/smbs_shreg.sv
module smbs_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         en;

  always_comb begin
    en  = ld | sh;
    q_n = ld ? ld_val : {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;
  end
endmodule

// File: rtl/smbs_slave_read.sv
module smbs_slave_read
  import smbs_pkg::*;
#(
  parameter int              DW          = 8,
  parameter logic [DW-2:0]   SLV_ADDR    = 7'h5A,
  parameter int              SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic          inhibit_i,
  input  logic          ack_wr_i,
  input  logic          ack_val_i,
  input  logic          dat_wr_i,
  input  logic [DW-1:0] dat_i,
  input  logic          si_clr_i,
  output logic          si_o,
  output logic          ackrq_o,
  output logic          err_o,
  output logic [3:0]    status_o
);
  localparam int            CW        = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL  = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST  = CW'(DW - 1);

  logic [1:0] rst_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  logic scl_rise, scl_fall, sda_now, start_det, stop_det;

  smbs_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_now(sda_now),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbs_state_e   state, state_n;
  logic [CW-1:0] bitcnt, bitcnt_n;
  logic          si, si_n, si_dly, ackrq, ackrq_n, err, err_n;
  logic          sta_f, sta_n, sto_f, sto_n, txmode, txmode_n;
  logic          mst_nack, mst_nack_n, ack_sel, ack_sel_n;
  logic [DW-1:0] dat_reg, dat_reg_n;
  logic          dat_vld, dat_vld_n, sda_oe, sda_oe_n;
  logic          sh_ld, sh_sh;
  logic [DW-1:0] sh_q;
  logic          addr_hit;

  smbs_shreg #(.W(DW)) shreg_i (
    .clk(clk), .rst_n(rst_sn), .ld(sh_ld), .ld_val(dat_reg),
    .sh(sh_sh), .sin(sda_now), .q(sh_q)
  );

  assign addr_hit = (sh_q[DW-1:1] == SLV_ADDR) && sh_q[0];

  always_comb begin
    state_n = state;   bitcnt_n = bitcnt;   si_n = si;     ackrq_n = ackrq;
    err_n = err;       sta_n = sta_f;       sto_n = sto_f; txmode_n = txmode;
    mst_nack_n = mst_nack; ack_sel_n = ack_sel;
    dat_reg_n = dat_reg;   dat_vld_n = dat_vld; sda_oe_n = sda_oe;
    sh_ld = 1'b0;      sh_sh = 1'b0;

    unique case (state)
      ST_ADDR: begin
        if (scl_rise) begin
          sh_sh    = 1'b1;
          bitcnt_n = bitcnt + CW'(1);
        end
        if (scl_fall && bitcnt == CNT_FULL) begin
          if (addr_hit) begin
            state_n = ST_AHOLD; si_n = 1'b1; ackrq_n = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_AHOLD: begin
        if (ack_wr_i) ack_sel_n = ack_val_i;
        if (si_clr_i) begin
          si_n = 1'b0; ackrq_n = 1'b0; sta_n = 1'b0;
          if (ack_sel) begin
            sda_oe_n = 1'b1; state_n = ST_AACK;
          end else begin
            state_n = ST_BLOCK;
          end
        end
      end
      ST_AACK: begin
        if (scl_fall) begin
          if (dat_vld) begin
            sh_ld = 1'b1; dat_vld_n = 1'b0; txmode_n = 1'b1;
            sda_oe_n = ~dat_reg[DW-1]; bitcnt_n = '0; state_n = ST_TX;
          end else begin
            sda_oe_n = 1'b0; state_n = ST_PASS;
          end
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          bitcnt_n = bitcnt + CW'(1);
          if (bitcnt == CNT_LAST) begin
            sda_oe_n = 1'b0; state_n = ST_MACK;
          end else begin
            sh_sh = 1'b1; sda_oe_n = ~sh_q[DW-2];
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) mst_nack_n = sda_now;
        if (scl_fall) begin
          si_n = 1'b1; state_n = ST_THOLD;
        end
      end
      ST_THOLD: begin
        if (si_clr_i) begin
          si_n = 1'b0; sta_n = 1'b0;
          if (!mst_nack && dat_vld) begin
            sh_ld = 1'b1; dat_vld_n = 1'b0; sda_oe_n = ~dat_reg[DW-1];
            bitcnt_n = '0; state_n = ST_TX;
          end else begin
            txmode_n = 1'b0; state_n = ST_PASS;
          end
        end
      end
      default: ;
    endcase

    if (dat_wr_i) begin
      if (state == ST_THOLD && mst_nack) begin
        err_n = 1'b1;
      end else begin
        dat_reg_n = dat_i; dat_vld_n = 1'b1;
      end
    end

    if (start_det) begin
      sto_n = 1'b0; err_n = 1'b0; bitcnt_n = '0; txmode_n = 1'b0;
      dat_vld_n = 1'b0; ack_sel_n = 1'b0; sda_oe_n = 1'b0;
      si_n = 1'b0; ackrq_n = 1'b0;
      state_n = inhibit_i ? ST_IDLE : ST_ADDR;
      sta_n   = ~inhibit_i;
    end else if (stop_det) begin
      state_n = ST_IDLE; txmode_n = 1'b0; sto_n = 1'b1;
      sta_n = 1'b0; sda_oe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state <= ST_IDLE;  bitcnt <= '0;   si <= 1'b0;     si_dly <= 1'b0;
      ackrq <= 1'b0;     err <= 1'b0;    sta_f <= 1'b0;  sto_f <= 1'b0;
      txmode <= 1'b0;    mst_nack <= 1'b0; ack_sel <= 1'b0;
      dat_reg <= '0;     dat_vld <= 1'b0;  sda_oe <= 1'b0;
    end else begin
      state <= state_n;  bitcnt <= bitcnt_n; si <= si_n;  si_dly <= si;
      ackrq <= ackrq_n;  err <= err_n;   sta_f <= sta_n; sto_f <= sto_n;
      txmode <= txmode_n; mst_nack <= mst_nack_n; ack_sel <= ack_sel_n;
      dat_reg <= dat_reg_n; dat_vld <= dat_vld_n; sda_oe <= sda_oe_n;
    end
  end

  assign scl_oe_o = si | si_dly;
  assign sda_oe_o = sda_oe;
  assign si_o     = si;
  assign ackrq_o  = ackrq;
  assign err_o    = err;
  assign status_o = {1'b0, txmode, sta_f, sto_f};
endmodule

// File: rtl/smbs_slave_read_chk.sv
module smbs_slave_read_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_line,
  input logic si,
  input logic ackrq,
  input logic err,
  input logic dat_wr,
  input logic si_clr,
  input logic sda_oe,
  input logic txmode,
  input logic stop_det
);
  // R3: the ACK request only exists while the interrupt is pending
  a_r3_ackrq_needs_si: assert property (@(posedge clk) disable iff (!rst_n)
    ackrq |-> si);

  // R9: the error flag is only set by a firmware data write
  a_r9_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(dat_wr));

  // R5: the slave starts pulling SDA only while SCL is low
  a_r5_sda_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_line);

  // R2: an interrupt is raised only while SCL is low
  a_r2_si_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> !scl_line);

  // R10: a STOP ends transmit mode
  a_r10_stop_ends_tx: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !txmode);

  // R6: clearing the interrupt takes effect on the next cycle
  a_r6_si_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (si && si_clr) |=> !si);
endmodule

bind smbs_slave_read smbs_slave_read_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_line(scl_i), .si(si_o), .ackrq(ackrq_o),
  .err(err_o), .dat_wr(dat_wr_i), .si_clr(si_clr_i), .sda_oe(sda_oe_o),
  .txmode(status_o[2]), .stop_det(stop_det)
);

// File: tb/smbs_slave_read_tb_top.sv
`timescale 1ns/1ps
module smbs_slave_read_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, scl_m, sda_m, inhibit, ack_wr, ack_val, dat_wr, si_clr;
  logic [7:0] dat;
  logic       scl_oe, sda_oe, si, ackrq, err;
  logic [3:0] status;
  logic       scl_bus, sda_bus;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  smbs_slave_read dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .inhibit_i(inhibit),
    .ack_wr_i(ack_wr), .ack_val_i(ack_val), .dat_wr_i(dat_wr), .dat_i(dat),
    .si_clr_i(si_clr), .si_o(si), .ackrq_o(ackrq), .err_o(err), .status_o(status)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // {expect_si, inhibit, address byte}; slave address 7'h5A
  localparam logic [9:0] VEC [7] = '{
    10'h2B5,  // match, read
    10'h0B4,  // match, write
    10'h0B7,  // address 5B, read
    10'h035,  // address 1A, read
    10'h1B5,  // match, read, inhibited
    10'h0F5,  // address 7A, read
    10'h2B5   // match, read again
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; cyc(2);
    scl_m = 1'b1; wait_scl_high(); cyc(8);
    sda_m = 1'b0; cyc(8);
    scl_m = 1'b0; cyc(6);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; cyc(6);
    scl_m = 1'b1; wait_scl_high(); cyc(8);
    sda_m = 1'b1; cyc(8);
  endtask

  task automatic m_bit(input logic b, output logic smp);
    sda_m = b; cyc(8);
    scl_m = 1'b1; wait_scl_high(); cyc(4);
    smp = sda_bus; cyc(4);
    scl_m = 1'b0; cyc(4);
  endtask

  task automatic m_byte_out(input logic [7:0] v);
    logic s;
    for (int k = 7; k >= 0; k--) m_bit(v[k], s);
  endtask

  task automatic m_byte_in(output logic [7:0] v);
    logic s;
    for (int k = 7; k >= 0; k--) begin
      m_bit(1'b1, s);
      v[k] = s;
    end
  endtask

  task automatic fw_ack(input logic v);
    ack_val = v; ack_wr = 1'b1; cyc(1); ack_wr = 1'b0;
  endtask

  task automatic fw_dat(input logic [7:0] v);
    dat = v; dat_wr = 1'b1; cyc(1); dat_wr = 1'b0;
  endtask

  task automatic fw_clr();
    si_clr = 1'b1; cyc(1); si_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic       s;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; inhibit = 1'b0;
    ack_wr = 1'b0; ack_val = 1'b0; dat_wr = 1'b0; dat = '0; si_clr = 1'b0;
    cyc(4); rst_n = 1'b1; cyc(6);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 si", si, 0);
    chk("R1 ackrq", ackrq, 0);
    chk("R1 err", err, 0);
    chk("R1 status", status, 4'b0000);

    // R2 / R4: address vectors
    for (int i = 0; i < 7; i++) begin
      inhibit = VEC[i][8];
      m_start();
      m_byte_out(VEC[i][7:0]);
      cyc(2);
      chk("R2 si after address", si, VEC[i][9]);
      chk("R2 ackrq after address", ackrq, VEC[i][9]);
      if (VEC[i][9]) begin
        scl_m = 1'b1; cyc(10);
        chk("R2 SCL stretched", scl_bus, 0);
        scl_m = 1'b0; cyc(2);
        fw_ack(1'b0); fw_clr(); cyc(2);
        m_bit(1'b1, s);
        chk("R4 address NACK leaves SDA high", s, 1);
      end else begin
        m_bit(1'b1, s);
        chk("R2 no ACK on ignored address", s, 1);
      end
      m_stop();
      inhibit = 1'b0;
    end

    // R3 R5 R6 R7 R10: two-byte read, master ACK then NACK
    m_start();
    chk("R10 status after START", status, 4'b0010);
    m_byte_out(8'hB5); cyc(2);
    chk("R2 si on matching read", si, 1);
    fw_ack(1'b1); fw_dat(8'hC3); fw_clr(); cyc(2);
    chk("R3 ackrq clears with si", ackrq, 0);
    m_bit(1'b1, s);
    chk("R3 address ACK driven", s, 0);
    cyc(2);
    chk("R5 R10 status in transmit", status, 4'b0100);
    m_byte_in(b);
    chk("R5 first byte MSB first", b, 8'hC3);
    chk("R6 no si before master ack", si, 0);
    m_bit(1'b0, s); cyc(2);
    chk("R6 si after master ack clock", si, 1);
    fw_dat(8'h5E); fw_clr(); cyc(2);
    m_byte_in(b);
    chk("R7 second byte", b, 8'h5E);
    m_bit(1'b1, s);
    chk("R6 SDA released for master ack", s, 1);
    cyc(2);
    chk("R6 si after NACK clock", si, 1);
    fw_clr(); cyc(2);
    chk("R8 R10 status after clear", status, 4'b0000);
    m_stop();
    chk("R10 status after STOP", status, 4'b0001);

    // R8: master ACK, firmware clears without new byte
    m_start(); m_byte_out(8'hB5); cyc(2);
    fw_ack(1'b1); fw_dat(8'hA5); fw_clr(); cyc(2);
    m_bit(1'b1, s);
    m_byte_in(b);
    chk("R5 byte A5", b, 8'hA5);
    m_bit(1'b0, s); cyc(2);
    chk("R6 si set", si, 1);
    fw_clr(); cyc(2);
    chk("R8 transmit mode dropped", status[2], 0);
    m_byte_in(b);
    chk("R8 SDA released afterwards", b, 8'hFF);
    m_bit(1'b1, s); cyc(2);
    chk("R8 no further interrupt", si, 0);
    m_stop();

    // R9: write after master NACK
    m_start(); m_byte_out(8'hB5); cyc(2);
    fw_ack(1'b1); fw_dat(8'h3C); fw_clr(); cyc(2);
    m_bit(1'b1, s);
    m_byte_in(b);
    m_bit(1'b1, s); cyc(2);
    chk("R9 err clear before write", err, 0);
    fw_dat(8'h77); cyc(1);
    chk("R9 err after late write", err, 1);
    fw_clr(); m_stop();
    chk("R9 err holds through STOP", err, 1);
    m_start();
    chk("R9 err cleared by START", err, 0);
    m_byte_out(8'hB4); m_bit(1'b1, s); m_stop();

    // R4: refused address blocks until repeated START
    m_start(); m_byte_out(8'hB5); cyc(2);
    fw_ack(1'b0); fw_clr(); cyc(2);
    m_bit(1'b1, s);
    m_byte_in(b);
    chk("R4 bus silent after refusal", b, 8'hFF);
    m_bit(1'b1, s); cyc(2);
    chk("R4 no interrupt while blocked", si, 0);
    m_start(); m_byte_out(8'hB5); cyc(2);
    chk("R4 repeated START re-arms", si, 1);
    fw_ack(1'b0); fw_clr(); cyc(2); m_bit(1'b1, s); m_stop();

    // R11: acknowledged address, no data loaded
    m_start(); m_byte_out(8'hB5); cyc(2);
    fw_ack(1'b1); fw_clr(); cyc(2);
    m_bit(1'b1, s);
    chk("R11 ACK still driven", s, 0);
    cyc(2);
    chk("R11 no transmit mode", status[2], 0);
    m_byte_in(b);
    chk("R11 bytes read as ones", b, 8'hFF);
    m_stop();

    // R1: reset in the middle of a transfer
    m_start(); m_byte_out(8'hB5); cyc(2);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
    chk("R1 si after mid reset", si, 0);
    chk("R1 scl_oe after mid reset", scl_oe, 0);
    chk("R1 status after mid reset", status, 4'b0000);
    m_stop();

    done = 1'b1;
    finish_run();
  end
endmodule